// File: doc/BRIEF.md
# Pin Interrupt Sense and Latch Unit

This block watches sixteen general interrupt request pins and one non-maskable interrupt pin. Each pin is brought into the clock domain through a two-stage synchroniser. It is then judged against a programmable sense mode and latched into a per-pin status flag. Every flag drives an active-high level output toward a parent interrupt controller. That output stays high for as long as the flag is set.

Software reaches the unit over a plain 32-bit register port with an address, a write strobe, write data and registered read data. The general pins each take one of four sense modes:

- low level
- falling edge
- rising edge
- either edge

The non-maskable pin selects falling or rising edge. In the edge modes a flag stays set until software writes a one to its bit in the matching clear register. In low-level mode the flag simply mirrors the pin: it is set while the pin is low, and the clear register cannot touch it.

Top module: `pin_irq_detect`

## Requirements
- R1: After a synchronous reset every status flag, `irq_out` and `nmi_out` are low, and both sense registers read back 0 (all pins low-level, non-maskable pin falling edge).
- R2: The general sense register at offset 0x18 holds pin n's 2-bit mode in bits [2n+1:2n], readable in full. The non-maskable sense register at 0x08 holds one bit at bit 0 and reads 0 elsewhere. An unmapped offset reads 0. Read data appears on the clock edge after the address is presented.
- R3: Mode 0 (low level): the flag equals the inverse of the synchronised pin, so it drops without software action when the pin returns high. A write to the clear register leaves it unchanged.
- R4: Mode 1 (falling edge): a high-to-low pin transition sets the flag, and a low-to-high transition does not.
- R5: Mode 2 (rising edge): a low-to-high pin transition sets the flag, and a high-to-low transition does not.
- R6: Mode 3 (either edge): any pin transition sets the flag.
- R7: In edge modes, writing 1 to bit n of offset 0x14 clears flag n. Bits written 0 leave their flags unchanged. Flag n is read at bit n of offset 0x10.
- R8: When a detected edge and a clear write for the same flag land in the same cycle, the flag stays set.
- R9: The non-maskable flag is read at bit 0 of offset 0x00 and cleared by writing 1 to bit 0 of offset 0x04. Sense bit value 0 selects falling edge and 1 selects rising edge.
- R10: Each output `irq_out[n]` and `nmi_out` equals its status flag at all times.
- R11: A pin change presented before clock edge k shows in the flag and output right after edge k+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | NUM_PINS | Asynchronous general interrupt pins |
| nmi_pin | input | 1 | Asynchronous non-maskable interrupt pin |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| irq_out | output | NUM_PINS | Level interrupt per general pin, high while its flag is set |
| nmi_out | output | 1 | Level non-maskable interrupt, high while its flag is set |

## Verification
The bench sweeps every sense mode, both uniformly across all pins and in a mixed per-pin layout. It drives pin patterns and compares flags against an arithmetic model.

It targets three timing corners:
- A clear write that coincides with a fresh edge. A design that gave the clear priority would drop that interrupt.
- The exact third-edge latency. An off-by-one pipeline would either raise the flag a cycle early or a cycle late.
- A clear in level mode. A design that honoured it would lose a still-active request.

The non-maskable pin is checked in both polarities. This catches a swapped sense encoding, which would fire on the wrong transition.

// File: rtl/pid_pkg.sv
package pid_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_BOTH = 2'd3
  } sense_e;

  // Register byte offsets
  localparam logic [7:0] OFS_NMI_STAT  = 8'h00;
  localparam logic [7:0] OFS_NMI_CLR   = 8'h04;
  localparam logic [7:0] OFS_NMI_SENSE = 8'h08;
  localparam logic [7:0] OFS_IRQ_STAT  = 8'h10;
  localparam logic [7:0] OFS_IRQ_CLR   = 8'h14;
  localparam logic [7:0] OFS_IRQ_SENSE = 8'h18;

endpackage

// File: rtl/pid_sync.sv
module pid_sync #(
  parameter int   WIDTH   = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_LVL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= {WIDTH{RST_LVL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pid_detect.sv
module pid_detect
  import pid_pkg::*;
#(
  parameter logic RST_LVL = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       smp,
  input  logic [1:0] sense,
  input  logic       clr,
  output logic       flag
);

  logic prev_q;
  logic ev;
  logic flag_d;

  always_comb begin
    unique case (sense_e'(sense))
      SENSE_FALL: ev = prev_q & ~smp;
      SENSE_RISE: ev = ~prev_q & smp;
      SENSE_BOTH: ev = prev_q ^ smp;
      default:    ev = 1'b0;
    endcase
    if (sense_e'(sense) == SENSE_LOW) flag_d = ~smp;
    else                              flag_d = ev | (flag & ~clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= RST_LVL;
      flag   <= 1'b0;
    end else begin
      prev_q <= smp;
      flag   <= flag_d;
    end
  end

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pid_pkg::*;
#(
  parameter int   NUM_PINS    = 16,
  parameter int   ADDR_W      = 8,
  parameter int   DATA_W      = 32,
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_LVL    = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_pin,
  input  logic                nmi_pin,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_PINS-1:0] irq_out,
  output logic                nmi_out
);

  localparam int SENSE_W = 2 * NUM_PINS;

  logic [SENSE_W-1:0]  irq_sense_q;
  logic                nmi_sense_q;
  logic [NUM_PINS-1:0] irq_smp;
  logic                nmi_smp;
  logic [NUM_PINS-1:0] irq_clr;
  logic                nmi_clr;
  logic [DATA_W-1:0]   rd_d;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  // Input synchronisers
  pid_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES), .RST_LVL(IDLE_LVL)) i_irq_sync (
    .clk(clk), .rst(rst), .d(irq_pin), .q(irq_smp)
  );
  pid_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_LVL(IDLE_LVL)) i_nmi_sync (
    .clk(clk), .rst(rst), .d(nmi_pin), .q(nmi_smp)
  );

  // Sense registers
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_sense_q <= '0;
      nmi_sense_q <= 1'b0;
    end else if (bus_we) begin
      if (hit(bus_addr, OFS_IRQ_SENSE)) irq_sense_q <= bus_wdata[SENSE_W-1:0];
      if (hit(bus_addr, OFS_NMI_SENSE)) nmi_sense_q <= bus_wdata[0];
    end
  end

  assign irq_clr = (bus_we && hit(bus_addr, OFS_IRQ_CLR)) ? bus_wdata[NUM_PINS-1:0] : '0;
  assign nmi_clr = bus_we && hit(bus_addr, OFS_NMI_CLR) && bus_wdata[0];

  // Per-pin detectors
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    pid_detect #(.RST_LVL(IDLE_LVL)) i_det (
      .clk(clk), .rst(rst), .smp(irq_smp[g]),
      .sense(irq_sense_q[2*g +: 2]), .clr(irq_clr[g]), .flag(irq_out[g])
    );
  end

  // Non-maskable pin: sense bit 0 -> falling (mode 1), 1 -> rising (mode 2)
  pid_detect #(.RST_LVL(IDLE_LVL)) i_nmi_det (
    .clk(clk), .rst(rst), .smp(nmi_smp),
    .sense({nmi_sense_q, ~nmi_sense_q}), .clr(nmi_clr), .flag(nmi_out)
  );

  // Registered read port
  always_comb begin
    rd_d = '0;
    if      (hit(bus_addr, OFS_NMI_STAT))  rd_d[0] = nmi_out;
    else if (hit(bus_addr, OFS_NMI_SENSE)) rd_d[0] = nmi_sense_q;
    else if (hit(bus_addr, OFS_IRQ_STAT))  rd_d[NUM_PINS-1:0] = irq_out;
    else if (hit(bus_addr, OFS_IRQ_SENSE)) rd_d[SENSE_W-1:0] = irq_sense_q;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end

endmodule

// File: rtl/pin_irq_detect_chk.sv
module pin_irq_detect_chk
  import pid_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_PINS-1:0]   irq_pin,
  input logic                  nmi_pin,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_we,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic [NUM_PINS-1:0]   irq_out,
  input logic                  nmi_out,
  input logic [2*NUM_PINS-1:0] irq_sense,
  input logic                  nmi_sense
);

  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  logic irq_clr_wr, nmi_clr_wr;
  assign irq_clr_wr = bus_we && (bus_addr == ADDR_W'(OFS_IRQ_CLR));
  assign nmi_clr_wr = bus_we && (bus_addr == ADDR_W'(OFS_NMI_CLR)) && bus_wdata[0];

  // R1: outputs low in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (irq_out == '0 && !nmi_out));

  // R9: non-maskable flag only falls after a clear write
  a_r9_nmi_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(nmi_out) |-> $past(nmi_clr_wr));

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin_chk
    // R7: in edge modes a flag only falls after a clear write of its bit
    a_r7_edge_needs_clear: assert property (@(posedge clk) disable iff (rst)
      ($fell(irq_out[n]) && $past(irq_sense[2*n +: 2]) != 2'd0)
        |-> $past(irq_clr_wr && bus_wdata[n]));

    if (SYNC_STAGES == 2) begin : g_lat
      // R3 R11: level mode output is the inverted pin three edges back
      a_r3_level_follows: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd4 && $past(irq_sense[2*n +: 2]) == 2'd0)
          |-> irq_out[n] == !$past(irq_pin[n], 3));
      // R11: an edge-mode flag rises only after a pin transition at the right depth
      a_r11_edge_source: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd5 && $rose(irq_out[n]) && $past(irq_sense[2*n +: 2]) != 2'd0)
          |-> $past(irq_pin[n], 3) != $past(irq_pin[n], 4));
    end
  end

  if (SYNC_STAGES == 2) begin : g_nmi_lat
    // R9: non-maskable flag rises only on the selected transition
    a_r9_nmi_polarity: assert property (@(posedge clk) disable iff (rst)
      (since_rst >= 3'd5 && $rose(nmi_out))
        |-> ($past(nmi_pin, 3) == $past(nmi_sense) && $past(nmi_pin, 4) != $past(nmi_sense)));
  end

endmodule

bind pin_irq_detect pin_irq_detect_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
) i_chk (
  .clk(clk), .rst(rst), .irq_pin(irq_pin), .nmi_pin(nmi_pin),
  .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .irq_out(irq_out), .nmi_out(nmi_out),
  .irq_sense(irq_sense_q), .nmi_sense(nmi_sense_q)
);

// File: tb/test_pin_irq_detect.sv
module test_pin_irq_detect;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_pin = 16'hFFFF;
  logic        nmi_pin = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_out;
  logic        nmi_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] pins_m = 16'hFFFF;
  logic [15:0] exp_m  = 16'h0000;
  logic [31:0] sense_m = 32'h0;

  always #4 clk = ~clk;

  pin_irq_detect i_pin_irq_detect (
    .clk(clk), .rst(rst), .irq_pin(irq_pin), .nmi_pin(nmi_pin),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out), .nmi_out(nmi_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [1:0] mode_of(input int n);
    return sense_m[2*n +: 2];
  endfunction

  task automatic apply(input logic [15:0] np);
    for (int n = 0; n < 16; n++) begin
      logic [1:0] m = mode_of(n);
      logic o = pins_m[n];
      logic w = np[n];
      if (m == 2'd0) exp_m[n] = ~w;
      else if ((m == 2'd1 && o && !w) || (m == 2'd2 && !o && w) || (m == 2'd3 && o != w))
        exp_m[n] = 1'b1;
    end
    @(negedge clk);
    irq_pin = np;
    pins_m = np;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_irq(input logic [15:0] mask);
    bus_write(8'h14, {16'h0, mask});
    for (int n = 0; n < 16; n++)
      if (mode_of(n) != 2'd0 && mask[n]) exp_m[n] = 1'b0;
  endtask

  task automatic set_sense(input logic [31:0] s);
    bus_write(8'h18, s);
    sense_m = s;
    for (int n = 0; n < 16; n++)
      if (mode_of(n) == 2'd0) exp_m[n] = ~pins_m[n];
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired (run did not complete)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    string tag;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(irq_out == 16'h0 && !nmi_out, "R1 outputs after reset", {15'h0, nmi_out, irq_out}, 32'h0);
    bus_read(8'h18, rd); check(rd == 32'h0, "R1 irq sense reset", rd, 32'h0);
    bus_read(8'h08, rd); check(rd == 32'h0, "R1 nmi sense reset", rd, 32'h0);
    bus_read(8'h10, rd); check(rd == 32'h0, "R1 irq status reset", rd, 32'h0);

    // Mode sweeps: uniform modes 0..3, then a mixed per-pin layout
    for (int cfg = 0; cfg < 5; cfg++) begin
      logic [31:0] s;
      case (cfg)
        0: begin s = 32'h00000000; tag = "R3 level"; end
        1: begin s = 32'h55555555; tag = "R4 falling"; end
        2: begin s = 32'hAAAAAAAA; tag = "R5 rising"; end
        3: begin s = 32'hFFFFFFFF; tag = "R6 both"; end
        default: begin s = 32'hE4E4E4E4; tag = "R10 mixed"; end
      endcase
      set_sense(s);
      clear_irq(16'hFFFF);
      check(irq_out == exp_m, {tag, " after clear"}, {16'h0, irq_out}, {16'h0, exp_m});
      for (int i = 0; i < 8; i++) begin
        logic [15:0] pat = 16'((i + 1) * 16'h9E37) ^ 16'(i * 16'h0F0F);
        apply(pat);
        check(irq_out == exp_m, tag, {16'h0, irq_out}, {16'h0, exp_m});
        bus_read(8'h10, rd);
        check(rd == {16'h0, exp_m}, "R10 status equals output", rd, {16'h0, exp_m});
      end
      clear_irq(16'hA5A5);
      check(irq_out == exp_m, cfg == 0 ? "R3 clear ignored" : "R7 partial clear",
            {16'h0, irq_out}, {16'h0, exp_m});
    end

    // R11 latency, rising mode on pin 3
    set_sense(32'hAAAAAAAA);
    apply(16'h0000);
    clear_irq(16'hFFFF);
    @(negedge clk);
    irq_pin[3] = 1'b1; pins_m[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(irq_out[3] == 1'b0, "R11 not after two edges", {31'h0, irq_out[3]}, 32'h0);
    @(negedge clk);
    check(irq_out[3] == 1'b1, "R11 set after third edge", {31'h0, irq_out[3]}, 32'h1);

    // R8 edge and clear in the same cycle
    apply(16'h0000);
    @(negedge clk);
    irq_pin[3] = 1'b1; pins_m[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 8'h14; bus_wdata = 32'h8; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    check(irq_out[3] == 1'b1, "R8 edge wins over clear", {31'h0, irq_out[3]}, 32'h1);
    clear_irq(16'h0008);
    check(irq_out[3] == 1'b0, "R7 clear without edge", {31'h0, irq_out[3]}, 32'h0);

    // R9 non-maskable pin
    @(negedge clk); nmi_pin = 1'b0;
    repeat (3) @(negedge clk);
    check(nmi_out == 1'b1, "R9 falling sets", {31'h0, nmi_out}, 32'h1);
    bus_read(8'h00, rd); check(rd == 32'h1, "R9 status read", rd, 32'h1);
    bus_write(8'h04, 32'h1);
    check(nmi_out == 1'b0, "R9 clear", {31'h0, nmi_out}, 32'h0);
    bus_write(8'h08, 32'h1);
    @(negedge clk); nmi_pin = 1'b1;
    repeat (3) @(negedge clk);
    check(nmi_out == 1'b1, "R9 rising sets", {31'h0, nmi_out}, 32'h1);
    bus_write(8'h04, 32'h1);
    @(negedge clk); nmi_pin = 1'b0;
    repeat (3) @(negedge clk);
    check(nmi_out == 1'b0, "R9 falling ignored in rising mode", {31'h0, nmi_out}, 32'h0);

    // R2 register layout
    bus_write(8'h08, 32'hFFFFFFFF);
    bus_read(8'h08, rd); check(rd == 32'h1, "R2 nmi sense width", rd, 32'h1);
    bus_write(8'h18, 32'h1234ABCD);
    bus_read(8'h18, rd); check(rd == 32'h1234ABCD, "R2 irq sense readback", rd, 32'h1234ABCD);
    bus_read(8'h0C, rd); check(rd == 32'h0, "R2 unmapped reads zero", rd, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule